// File: doc/BRIEF.md
# Right-Justified Stereo Serial Audio Receiver

This block turns a stereo serial audio stream into parallel sample words. It works entirely in the bit-clock domain. On every rising bit-clock edge it samples a serial data line and a frame clock. The frame clock is high while left-channel bits arrive and low while right-channel bits arrive. Each word is sent most significant bit first. It is aligned to the end of its half-frame: the least significant bit sits in the last bit-clock period before the frame clock toggles.

Because words are aligned to the closing edge, the receiver keeps a sliding window of the most recent bits. When it sees the frame clock change, it takes the last N bits as the word, where N is 16 or 24 as set by a static mode input. Any earlier bits in that half-frame fall out of the window. A half-frame may therefore be any length from N bit clocks upward.

When a right word is taken, the block presents it together with the left word that came before it and raises a one-cycle strobe. The outputs then hold until the next complete pair.

Top module: `rj_audio_rx`

## Requirements
- R1: Serial bits are taken MSB first. A captured word equals the last N bits sampled before the frame-clock change, with the final bit as bit 0. Earlier bits of the half-frame have no effect on the word.
- R2: The word received while the frame clock is sampled high is the left sample. It is captured at the high-to-low change.
- R3: The word received while the frame clock is sampled low is the right sample. At the low-to-high change, `left_word` and `right_word` are updated together and `pair_valid` is high for the next cycle.
- R4: With `wide_mode` = 0, N = 16. The words occupy bits 15..0 and bits 23..16 read zero.
- R5: With `wide_mode` = 1, N = 24. The words occupy bits 23..0.
- R6: The number of bit clocks per half-frame may vary from N upward (16, 24, 32, 64 and 128 are used) without changing the captured words.
- R7: `pair_valid` never stays high for two consecutive cycles. `left_word` and `right_word` change only in a cycle where `pair_valid` is high.
- R8: While `rst_n` is low, the outputs and `pair_valid` are zero. After reset, no strobe appears until a full left half-frame, begun after a frame-clock change, and the right half-frame that follows it have both been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Bit clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_clk | input | 1 | Frame clock: 1 = left half, 0 = right half |
| ser_data | input | 1 | Serial audio data, MSB first |
| wide_mode | input | 1 | Sample width: 0 = 16 bits, 1 = 24 bits |
| left_word | output | 24 | Left sample of the last complete pair |
| right_word | output | 24 | Right sample of the last complete pair |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
The bench builds the block with its default parameters: a 24-bit window and a 16-bit narrow width. This exposes the masking of the eight upper bits in narrow mode. The bench runs half-frames of 16, 24, 32, 64 and 128 bit clocks and fills the leading unused slots with random bits, so the window must discard them. It also switches width between frames and resets in the middle of the stream, which shows that the first partial frame produces no strobe.

// File: rtl/rj_audio_rx.sv
module rj_audio_rx #(
  parameter int WIDE_BITS   = 24,
  parameter int NARROW_BITS = 16
) (
  input  logic                 bit_clk,
  input  logic                 rst_n,
  input  logic                 frame_clk,
  input  logic                 ser_data,
  input  logic                 wide_mode,
  output logic [WIDE_BITS-1:0] left_word,
  output logic [WIDE_BITS-1:0] right_word,
  output logic                 pair_valid
);
  localparam int W = WIDE_BITS;
  localparam logic [W-1:0] NARROW_MASK = {{(W-NARROW_BITS){1'b0}}, {NARROW_BITS{1'b1}}};

  logic [W-1:0] window, left_hold, masked;
  logic frame_q, primed, armed, left_ok;

  wire edge_seen  = primed && (frame_clk != frame_q);
  wire left_done  = edge_seen && !frame_clk;
  wire right_done = edge_seen && frame_clk;

  assign masked = wide_mode ? window : (window & NARROW_MASK);

  always_ff @(posedge bit_clk) begin
    if (!rst_n) begin
      window     <= '0;
      left_hold  <= '0;
      frame_q    <= 1'b0;
      primed     <= 1'b0;
      armed      <= 1'b0;
      left_ok    <= 1'b0;
      left_word  <= '0;
      right_word <= '0;
      pair_valid <= 1'b0;
    end else begin
      window     <= {window[W-2:0], ser_data};
      frame_q    <= frame_clk;
      primed     <= 1'b1;
      pair_valid <= 1'b0;
      if (edge_seen) armed <= 1'b1;
      if (left_done) begin
        left_hold <= masked;
        left_ok   <= armed;
      end
      if (right_done && left_ok) begin
        left_word  <= left_hold;
        right_word <= masked;
        pair_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rj_audio_rx_chk.sv
module rj_audio_rx_chk #(
  parameter int W  = 24,
  parameter int NB = 16
) (
  input logic         bit_clk,
  input logic         rst_n,
  input logic         frame_clk,
  input logic         wide_mode,
  input logic [W-1:0] left_word,
  input logic [W-1:0] right_word,
  input logic         pair_valid
);
  p_strobe_after_rise_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
    pair_valid |-> ($past(frame_clk) && !$past(frame_clk, 2)));

  p_narrow_upper_zero_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (pair_valid && !wide_mode && !$past(wide_mode)) |->
      (left_word[W-1:NB] == '0 && right_word[W-1:NB] == '0));

  p_strobe_single_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    pair_valid |=> !pair_valid);

  p_hold_outputs_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !pair_valid |-> ($stable(left_word) && $stable(right_word)));

  p_reset_clears_r8: assert property (@(posedge bit_clk)
    !rst_n |=> (!pair_valid && left_word == '0 && right_word == '0));
endmodule

bind rj_audio_rx rj_audio_rx_chk #(.W(WIDE_BITS), .NB(NARROW_BITS)) u_chk (.*);

// File: tb/sim_rj_audio_rx.sv
module sim_rj_audio_rx;
  localparam int CLK_PERIOD = 10;

  logic bit_clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clk = 1'b1;
  logic ser_data = 1'b0;
  logic wide_mode = 1'b1;
  logic [23:0] left_word, right_word;
  logic pair_valid;

  int n_checks = 0;
  int n_fail = 0;
  logic prev_v = 1'b0;
  logic [23:0] exp_l[$];
  logic [23:0] exp_r[$];
  string exp_tag[$];
  logic [23:0] last_l = '0, last_r = '0;

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  rj_audio_rx u0 (
    .bit_clk(bit_clk), .rst_n(rst_n), .frame_clk(frame_clk), .ser_data(ser_data),
    .wide_mode(wide_mode), .left_word(left_word), .right_word(right_word),
    .pair_valid(pair_valid)
  );

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops expected pairs as strobes appear
  always @(negedge bit_clk) begin
    if (!rst_n) prev_v <= 1'b0;
    else begin
      if (pair_valid) begin
        if (prev_v) check(0, "R7 strobe width", 48'd1, 48'd0);
        if (exp_l.size() == 0) check(0, "R8 unexpected strobe", {left_word, right_word}, 48'd0);
        else begin
          automatic logic [23:0] el = exp_l.pop_front();
          automatic logic [23:0] er = exp_r.pop_front();
          automatic string t = exp_tag.pop_front();
          check({left_word, right_word} == {el, er}, {t, " R2 R3 pair"}, {left_word, right_word}, {el, er});
        end
      end
      prev_v <= pair_valid;
    end
  end

  task automatic send_half(input logic lvl, input logic [23:0] word, input int width,
                           input int nbits, input bit set_mode, input logic mode);
    for (int i = 0; i < nbits; i++) begin
      @(negedge bit_clk);
      frame_clk = lvl;
      if (nbits - 1 - i < width) ser_data = word[nbits-1-i];
      else ser_data = 1'($urandom() & 1);
      if (i == 1 && set_mode) wide_mode = mode;
    end
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input logic mode,
                            input int per_half, input bit push, input string tag);
    automatic int w = mode ? 24 : 16;
    send_half(1'b1, l, w, per_half, 1'b1, mode);
    send_half(1'b0, r, w, per_half, 1'b0, mode);
    if (push) begin
      last_l = mode ? l : {8'h00, l[15:0]};
      last_r = mode ? r : {8'h00, r[15:0]};
      exp_l.push_back(last_l);
      exp_r.push_back(last_r);
      exp_tag.push_back(tag);
    end
  endtask

  task automatic flush(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge bit_clk);
      frame_clk = 1'b1;
      ser_data = 1'($urandom() & 1);
    end
  endtask

  task automatic check_drained(input string req);
    check(exp_l.size() == 0, req, 48'(exp_l.size()), 48'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog", 48'd0, 48'd1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge bit_clk);
    check(pair_valid == 0 && left_word == 0 && right_word == 0, "R8 reset state",
          {left_word, right_word}, 48'd0);
    rst_n = 1'b1;
    // R8: first frame after reset yields no strobe
    send_frame(24'hABCDEF, 24'h123456, 1'b1, 32, 0, "R8");
    send_frame(24'h800001, 24'h7FFFFE, 1'b1, 32, 1, "R5 R1");
    send_frame(24'hFFFFFF, 24'h000000, 1'b1, 24, 1, "R6 exact24");
    send_frame(24'h5A5A5A, 24'hA5A5A5, 1'b1, 128, 1, "R6 long128");
    send_frame(24'h00C3F0, 24'hF00C30, 1'b1, 64, 1, "R6 64");
    send_frame(24'hFF1234, 24'hEE8001, 1'b0, 16, 1, "R4 exact16");
    send_frame(24'hC3FFFF, 24'h990000, 1'b0, 64, 1, "R4 R1 junk");
    send_frame(24'h00BEEF, 24'h00CAFE, 1'b0, 32, 1, "R4 R6 32");
    send_frame(24'h13579B, 24'h2468AC, 1'b1, 48, 1, "R5 back to wide");
    flush(4);
    check_drained("R3 all pairs delivered");
    for (int k = 0; k < 3; k++) begin
      flush(5);
      check(left_word == last_l && right_word == last_r && !pair_valid, "R7 hold",
            {left_word, right_word}, {last_l, last_r});
    end
    // mid-stream reset
    send_half(1'b1, 24'h111111, 24, 10, 1'b0, 1'b1);
    @(negedge bit_clk);
    rst_n = 1'b0;
    frame_clk = 1'b1;
    repeat (2) @(negedge bit_clk);
    check(pair_valid == 0 && left_word == 0 && right_word == 0, "R8 mid reset clears",
          {left_word, right_word}, 48'd0);
    rst_n = 1'b1;
    send_frame(24'h222222, 24'h333333, 1'b1, 32, 0, "R8");
    flush(3);
    check_drained("R8 no strobe for partial frame");
    send_frame(24'h444444, 24'h555555, 1'b1, 32, 1, "R8 first full");
    send_frame(24'h0F0F0F, 24'hF0F0F0, 1'b1, 40, 1, "R2 R3 distinct");
    flush(4);
    check_drained("R3 final pairs delivered");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule